// File: doc/BRIEF.md
# Direct-Page Effective Address Generator

This block works out the 16-bit effective address for a small 8-bit processor whose direct page is movable. It is given an addressing-mode code, the operand bytes that follow the opcode, the current X and Y index registers and the page-select status bit. For every mode the result is reported through one valid strobe. When a mode has to follow a two-byte pointer stored in the direct page, the block runs a short fetch over a synchronous read port that has one cycle of latency. When the operand is the immediate byte itself, the block flags it. For the post-incrementing register-indirect mode it also tells the register file to bump X.

A single `start` pulse in a cycle where `busy` is low hands a request to the block. The direct page begins at $0000 when `page_sel` is 0 and at $0100 when it is 1. Decoding, arithmetic and flag handling are left to the surrounding core.

Top module: `dp_ea_gen`

## Requirements
- R1: During reset and after it, `busy`, `ea_valid`, `ea_imm`, `x_inc` and `mem_rd_en` are all low.
- R2: A non-pointer mode accepted at a clock edge raises `ea_valid` for exactly the following cycle. Mode 1 (direct page) yields `page_sel`*$100 + `op_lo`. Mode 4 (absolute) yields {`op_hi`,`op_lo`}.
- R3: Mode 2 (page + X) and mode 3 (page + Y) add the index to `op_lo` modulo 256. The page number is never changed by the addition.
- R4: Mode 5 (absolute + X) and mode 6 (absolute + Y) add the zero-extended index to {`op_hi`,`op_lo`} modulo 65536.
- R5: Mode 7 (through X) and mode 8 (through X, post-increment) both yield `page_sel`*$100 + X.
- R6: Mode 8 raises `x_inc` for one cycle, the cycle right after `ea_valid`. No other mode ever raises `x_inc`.
- R7: Mode 9 (index before pointer) reads the low pointer byte at page + (`op_lo`+X mod 256) and then the high byte at the next offset, also wrapped inside the page. The read port returns data one cycle after `mem_rd_en`. `ea_valid` comes up in the fourth cycle after acceptance and carries the pointer.
- R8: Mode 10 (index after pointer) reads the pointer from page + `op_lo` and its successor in the page. It yields pointer + Y modulo 65536 with the same timing as R7.
- R9: `busy` is high while a pointer fetch is in progress. A `start` that arrives while `busy` is high is dropped and has no effect on the result or on the reads.
- R10: Mode 0 (immediate) raises `ea_valid` and `ea_imm` together for one cycle, with `ea_addr` = zero-extended `op_lo`. It performs no read.
- R11: Mode codes 11 to 15 produce no `ea_valid`, no read and no `x_inc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe |
| mode | input | 4 | Addressing-mode code |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| page_sel | input | 1 | Direct-page select bit |
| busy | output | 1 | Pointer fetch in progress |
| ea_valid | output | 1 | Result strobe |
| ea_addr | output | 16 | Effective address (or immediate value) |
| ea_imm | output | 1 | Result is an immediate operand |
| x_inc | output | 1 | Increment X this cycle |
| mem_rd_en | output | 1 | Read request |
| mem_rd_addr | output | 16 | Read address |
| mem_rd_data | input | 8 | Read data, one cycle after request |

## Verification
The bench builds the block with its default 8-bit data width, which gives a 16-bit address space. This keeps the wrap points within reach of a plain sweep: the page-offset carry from $FF, the pointer's high byte at offset $FF wrapping to $00, and the 16-bit carry beyond $FFFF. The sweep covers all sixteen mode codes, both page settings, and spread values of the operand and both indices. Expected addresses and read sequences come from arithmetic on a fixed memory pattern held in the bench.

// File: rtl/dp_ea_pkg.sv
package dp_ea_pkg;
  typedef enum logic [3:0] {
    AM_IMM     = 4'd0,
    AM_DP      = 4'd1,
    AM_DP_X    = 4'd2,
    AM_DP_Y    = 4'd3,
    AM_ABS     = 4'd4,
    AM_ABS_X   = 4'd5,
    AM_ABS_Y   = 4'd6,
    AM_REG_X   = 4'd7,
    AM_REG_XI  = 4'd8,
    AM_PTR_PRE = 4'd9,
    AM_PTR_PST = 4'd10
  } amode_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_LO   = 2'd1,
    FS_HI   = 2'd2,
    FS_FIN  = 2'd3
  } fstate_e;
endpackage

// File: rtl/dp_ea_rst_sync.sv
module dp_ea_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/dp_ea_direct.sv
module dp_ea_direct
  import dp_ea_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic [3:0]        mode,
  input  logic              page_sel,
  input  logic [DATA_W-1:0] op_lo,
  input  logic [DATA_W-1:0] op_hi,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  output logic [ADDR_W-1:0] ea,
  output logic              is_direct,
  output logic              is_ptr,
  output logic              is_imm,
  output logic              is_pinc,
  output logic [DATA_W-1:0] ptr_off,
  output logic [DATA_W-1:0] post_add
);
  logic [DATA_W-1:0] page_num;
  logic [DATA_W-1:0] off_x, off_y;
  logic [ADDR_W-1:0] abs_base;
  amode_e            am;

  always_comb begin
    am        = amode_e'(mode);
    page_num  = {{(DATA_W-1){1'b0}}, page_sel};
    off_x     = op_lo + idx_x;
    off_y     = op_lo + idx_y;
    abs_base  = {op_hi, op_lo};
    ea        = '0;
    is_direct = 1'b1;
    is_ptr    = 1'b0;
    is_imm    = 1'b0;
    is_pinc   = 1'b0;
    ptr_off   = op_lo;
    post_add  = '0;
    case (am)
      AM_IMM: begin
        ea     = {{DATA_W{1'b0}}, op_lo};
        is_imm = 1'b1;
      end
      AM_DP:     ea = {page_num, op_lo};
      AM_DP_X:   ea = {page_num, off_x};
      AM_DP_Y:   ea = {page_num, off_y};
      AM_ABS:    ea = abs_base;
      AM_ABS_X:  ea = abs_base + {{DATA_W{1'b0}}, idx_x};
      AM_ABS_Y:  ea = abs_base + {{DATA_W{1'b0}}, idx_y};
      AM_REG_X:  ea = {page_num, idx_x};
      AM_REG_XI: begin
        ea      = {page_num, idx_x};
        is_pinc = 1'b1;
      end
      AM_PTR_PRE: begin
        is_direct = 1'b0;
        is_ptr    = 1'b1;
        ptr_off   = off_x;
      end
      AM_PTR_PST: begin
        is_direct = 1'b0;
        is_ptr    = 1'b1;
        post_add  = idx_y;
      end
      default: is_direct = 1'b0;
    endcase
  end
endmodule

// File: rtl/dp_ea_fetch.sv
module dp_ea_fetch
  import dp_ea_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              page_sel,
  input  logic [DATA_W-1:0] ptr_off,
  input  logic [DATA_W-1:0] post_add,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              done,
  output logic [ADDR_W-1:0] ptr_ea
);
  fstate_e           st_q, st_d;
  logic [DATA_W-1:0] off_q, add_q, lo_q;
  logic              pg_q;
  logic              ld_req, ld_lo;
  logic [DATA_W-1:0] off_nx;
  logic [DATA_W-1:0] page_num;

  always_comb begin
    st_d   = st_q;
    ld_req = 1'b0;
    ld_lo  = 1'b0;
    done   = 1'b0;
    case (st_q)
      FS_IDLE: if (go) begin
        st_d   = FS_LO;
        ld_req = 1'b1;
      end
      FS_LO:  st_d = FS_HI;
      FS_HI: begin
        st_d  = FS_FIN;
        ld_lo = 1'b1;
      end
      FS_FIN: begin
        st_d = FS_IDLE;
        done = 1'b1;
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      add_q <= '0;
      pg_q  <= 1'b0;
    end else if (ld_req) begin
      off_q <= ptr_off;
      add_q <= post_add;
      pg_q  <= page_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (ld_lo) lo_q <= mem_rd_data;
  end

  always_comb begin
    page_num    = {{(DATA_W-1){1'b0}}, pg_q};
    off_nx      = off_q + {{(DATA_W-1){1'b0}}, 1'b1};
    busy        = (st_q != FS_IDLE);
    mem_rd_en   = (st_q == FS_LO) || (st_q == FS_HI);
    mem_rd_addr = {page_num, (st_q == FS_HI) ? off_nx : off_q};
    ptr_ea      = {mem_rd_data, lo_q} + {{DATA_W{1'b0}}, add_q};
  end
endmodule

// File: rtl/dp_ea_gen.sv
module dp_ea_gen #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [DATA_W-1:0] op_lo,
  input  logic [DATA_W-1:0] op_hi,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  input  logic              page_sel,
  output logic              busy,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea_addr,
  output logic              ea_imm,
  output logic              x_inc,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data
);
  logic              srst_n;
  logic [ADDR_W-1:0] dir_ea, ptr_ea;
  logic              is_direct, is_ptr, is_imm, is_pinc;
  logic [DATA_W-1:0] ptr_off, post_add;
  logic              accept, go, fetch_done;
  logic              valid_d, imm_d, pinc_d, xinc_d;
  logic [ADDR_W-1:0] ea_d;
  logic              pinc_q;

  dp_ea_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dp_ea_direct #(.DATA_W(DATA_W)) u_dir (
    .mode      (mode),
    .page_sel  (page_sel),
    .op_lo     (op_lo),
    .op_hi     (op_hi),
    .idx_x     (idx_x),
    .idx_y     (idx_y),
    .ea        (dir_ea),
    .is_direct (is_direct),
    .is_ptr    (is_ptr),
    .is_imm    (is_imm),
    .is_pinc   (is_pinc),
    .ptr_off   (ptr_off),
    .post_add  (post_add)
  );

  dp_ea_fetch #(.DATA_W(DATA_W)) u_fetch (
    .clk         (clk),
    .rst_n       (srst_n),
    .go          (go),
    .page_sel    (page_sel),
    .ptr_off     (ptr_off),
    .post_add    (post_add),
    .mem_rd_data (mem_rd_data),
    .busy        (busy),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .done        (fetch_done),
    .ptr_ea      (ptr_ea)
  );

  always_comb begin
    accept  = start && !busy;
    go      = accept && is_ptr;
    valid_d = (accept && is_direct) || fetch_done;
    imm_d   = accept && is_imm;
    pinc_d  = accept && is_pinc;
    xinc_d  = pinc_q;
    ea_d    = fetch_done ? ptr_ea : dir_ea;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ea_valid <= 1'b0;
      ea_imm   <= 1'b0;
      pinc_q   <= 1'b0;
      x_inc    <= 1'b0;
    end else begin
      ea_valid <= valid_d;
      ea_imm   <= imm_d;
      pinc_q   <= pinc_d;
      x_inc    <= xinc_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      ea_addr <= '0;
    else if (valid_d) ea_addr <= ea_d;
  end
endmodule

// File: rtl/dp_ea_gen_chk.sv
module dp_ea_gen_chk #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ea_valid,
  input logic              ea_imm,
  input logic              x_inc,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr
);
  assert_read_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);

  assert_valid_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> !busy);

  assert_xinc_after_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    x_inc |-> $past(ea_valid) && !ea_valid);

  assert_imm_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ea_imm |-> ea_valid);

  assert_ptr_in_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr[ADDR_W-1:DATA_W] <= {{(DATA_W-1){1'b0}}, 1'b1}));

  assert_ptr_next_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |->
      (mem_rd_addr[ADDR_W-1:DATA_W] == $past(mem_rd_addr[ADDR_W-1:DATA_W])) &&
      (mem_rd_addr[DATA_W-1:0] ==
         $past(mem_rd_addr[DATA_W-1:0]) + {{(DATA_W-1){1'b0}}, 1'b1}));
endmodule

bind dp_ea_gen dp_ea_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .ea_valid    (ea_valid),
  .ea_imm      (ea_imm),
  .x_inc       (x_inc),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr)
);

// File: tb/test_dp_ea_gen.sv
module test_dp_ea_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  mode;
  logic [7:0]  op_lo, op_hi, idx_x, idx_y;
  logic        page_sel;
  logic        busy, ea_valid, ea_imm, x_inc, mem_rd_en;
  logic [15:0] ea_addr, mem_rd_addr;
  logic [7:0]  mem_q;

  int n_chk;
  int n_fail;
  bit ended;

  dp_ea_gen i_dp_ea_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y),
    .page_sel(page_sel), .busy(busy), .ea_valid(ea_valid),
    .ea_addr(ea_addr), .ea_imm(ea_imm), .x_inc(x_inc),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_q <= memf(mem_rd_addr);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int m);
    case (m)
      0: return "R10";
      1, 4: return "R2";
      2, 3: return "R3";
      5, 6: return "R4";
      7: return "R5";
      8: return "R6";
      9: return "R7";
      10: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic run_one(input int m, input bit p, input logic [7:0] lo,
                         input logic [7:0] hi, input logic [7:0] x, input logic [7:0] y);
    int vcyc, xcyc, nrd, exp_vc, exp_xc, exp_nrd;
    bit vimm, exp_imm;
    logic [15:0] vea, exp_ea, page, rda [4], exp_rd [2];
    logic [7:0] po;
    string rq;
    vcyc = 0; xcyc = 0; nrd = 0; vimm = 0; vea = '0;
    rq = req_of(m);
    @(negedge clk);
    start = 1'b1; mode = 4'(m); page_sel = p;
    op_lo = lo; op_hi = hi; idx_x = x; idx_y = y;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (ea_valid && vcyc == 0) begin vcyc = k; vea = ea_addr; vimm = ea_imm; end
      if (x_inc && xcyc == 0) xcyc = k;
      if (mem_rd_en && nrd < 4) begin rda[nrd] = mem_rd_addr; nrd++; end
    end
    page = p ? 16'h0100 : 16'h0000;
    exp_vc = 1; exp_xc = 0; exp_nrd = 0; exp_imm = 0; exp_ea = '0;
    case (m)
      0: begin exp_ea = {8'h00, lo}; exp_imm = 1; end
      1: exp_ea = page | {8'h00, lo};
      2: exp_ea = page | {8'h00, 8'(lo + x)};
      3: exp_ea = page | {8'h00, 8'(lo + y)};
      4: exp_ea = {hi, lo};
      5: exp_ea = {hi, lo} + {8'h00, x};
      6: exp_ea = {hi, lo} + {8'h00, y};
      7: exp_ea = page | {8'h00, x};
      8: begin exp_ea = page | {8'h00, x}; exp_xc = 2; end
      9, 10: begin
        po = (m == 9) ? 8'(lo + x) : lo;
        exp_rd[0] = page | {8'h00, po};
        exp_rd[1] = page | {8'h00, 8'(po + 8'd1)};
        exp_ea = {memf(exp_rd[1]), memf(exp_rd[0])} + ((m == 10) ? {8'h00, y} : 16'h0000);
        exp_vc = 4; exp_nrd = 2;
      end
      default: exp_vc = 0;
    endcase
    check(vcyc == exp_vc, {rq, " valid cycle"}, vcyc, exp_vc);
    if (exp_vc != 0 && vcyc == exp_vc) begin
      check(vea == exp_ea, {rq, " address"}, int'(vea), int'(exp_ea));
      check(vimm == exp_imm, {rq, " imm flag"}, int'(vimm), int'(exp_imm));
    end
    check(xcyc == exp_xc, {rq, " x_inc cycle R6"}, xcyc, exp_xc);
    check(nrd == exp_nrd, {rq, " read count"}, nrd, exp_nrd);
    if (exp_nrd == 2 && nrd == 2) begin
      check(rda[0] == exp_rd[0], {rq, " low pointer read"}, int'(rda[0]), int'(exp_rd[0]));
      check(rda[1] == exp_rd[1], {rq, " high pointer read"}, int'(rda[1]), int'(exp_rd[1]));
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; ended = 0;
    rst_n = 1'b0; start = 1'b0; mode = '0; page_sel = 1'b0;
    op_lo = '0; op_hi = '0; idx_x = '0; idx_y = '0;
    repeat (3) @(negedge clk);
    // R1: idle during reset
    check(!busy && !ea_valid && !ea_imm && !x_inc && !mem_rd_en, "R1 in reset", 1, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !ea_valid && !ea_imm && !x_inc && !mem_rd_en, "R1 after reset", 1, 0);

    // Sweep over modes, page, operand and index values
    for (int m = 0; m < 16; m++)
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < 7; a++)
          for (int xi = 0; xi < 6; xi++)
            for (int yi = 0; yi < 4; yi++)
              run_one(m, p[0], 8'(a * 37 + 31), 8'(8'hFF - a * 41),
                      8'(xi * 51), 8'(yi * 85));

    // Corner cases: page wrap of pointer byte, 16-bit carry
    run_one(9, 1'b0, 8'hF0, 8'h00, 8'h0F, 8'h00);   // R7 pointer at $FF, high at $00
    run_one(10, 1'b1, 8'hFF, 8'h00, 8'h00, 8'hFF);  // R8 pointer wrap in page $01
    run_one(5, 1'b0, 8'hFF, 8'hFF, 8'h01, 8'h00);   // R4 carry beyond $FFFF
    run_one(2, 1'b1, 8'hFF, 8'h00, 8'h01, 8'h00);   // R3 stays in page $01

    // R9: second start while busy is dropped
    begin
      int nval, nrd;
      logic [15:0] first_ea;
      nval = 0; nrd = 0; first_ea = '0;
      @(negedge clk);
      start = 1'b1; mode = 4'd10; page_sel = 1'b0;
      op_lo = 8'h20; op_hi = 8'h00; idx_x = 8'h00; idx_y = 8'h03;
      @(negedge clk);
      check(busy == 1'b1, "R9 busy during fetch", int'(busy), 1);
      mode = 4'd4; op_lo = 8'h55; op_hi = 8'h66;
      for (int k = 0; k < 8; k++) begin
        if (mem_rd_en) nrd++;
        @(negedge clk);
        if (k == 0) start = 1'b0;
        if (ea_valid) begin
          if (nval == 0) first_ea = ea_addr;
          nval++;
        end
      end
      check(nval == 1, "R9 single result", nval, 1);
      check(first_ea == {memf(16'h0021), memf(16'h0020)} + 16'h0003,
            "R9 result unchanged", int'(first_ea),
            int'({memf(16'h0021), memf(16'h0020)} + 16'h0003));
      check(nrd == 2, "R9 read count", nrd, 2);
    end

    finish_run();
  end
endmodule